// File: doc/BRIEF.md
# Four-Phase Sampling Time-to-Digital Channel

This block timestamps the rising edges of one hit line with a resolution of a quarter of a clock period, at low logic cost. It suits drift-chamber timing, where sub-nanosecond bins are enough. Four copies of one clock, shifted from each other by a quarter period, each sample the hit line once per period. The four samples are moved into the domain of the 0° clock and put in time order. A small line-state machine then looks for the first low-to-high step, and the position of that step becomes a 2-bit fine time. One free-running plain binary counter in the 0° domain supplies the coarse time.

A timestamp leaves the block as a one-cycle valid strobe with the coarse and fine fields beside it. The full time is `{coarse, fine}` in units of a quarter period. At a 360 MHz clock, for example, the effective sampling rate is 1.44 GHz and one fine step is about 0.69 ns. The edge machine has two states, LINE_LOW and LINE_HIGH, which record the level the line had at the last (270°) sample of the previous period. After every reference cycle the machine moves to LINE_HIGH when that cycle's last sample is 1 and to LINE_LOW when it is 0. Reset puts it in LINE_LOW.

Top module: `mpt_tdc_channel`

## Requirements
- R1: Sample i (i = 0..3) is taken on the rising edge of clk_ph[i]. clk_ph[i] lags clk_ph[0] by i quarter periods. A rise first seen in sample i reports fine code i.
- R2: A rise in the reference cycle that begins at clk_ph[0] edge k is reported by ts_valid, which is high for exactly the one cycle after clk_ph[0] edge k+3.
- R3: Sample 0 is compared with sample 3 of the previous cycle, and each later sample with the sample just before it. The fine code is the lowest index i where sample i is 1 and the sample before it is 0.
- R4: One reference cycle yields at most one timestamp. A second rise later in the same cycle is ignored and does not change the fine code.
- R5: A line that stays low, stays high or only falls produces no timestamp.
- R6: The coarse counter is 0 during the cycle that follows reset release and increases by one at every clk_ph[0] edge. ts_coarse is the counter value of the cycle that holds the first set sample of the rise.
- R7: The coarse counter is 12 bits wide and wraps from 4095 to 0. A rise in the cycle with value 4095 reports 4095, and later rises report the wrapped values.
- R8: While rst_n is low, ts_valid, ts_coarse and ts_fine are 0. A rise that is still in the pipeline when reset is asserted is discarded and is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ph | input | NUM_PHASES (4) | Phase clocks; bit i lags bit 0 by i quarter periods; bit 0 is the reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| hit | input | 1 | Hit line to be timed |
| ts_valid | output | 1 | One-cycle strobe marking a new timestamp |
| ts_coarse | output | COARSE_W (12) | Coarse time: reference cycle count of the rise |
| ts_fine | output | $clog2(NUM_PHASES) (2) | Fine time: quarter-period index of the rise |

## Verification
The bench uses the default parameters: four phases and a 12-bit coarse counter. With four phases every fine code, and every ordering of two rises within one period, can be reached by setting the line between the phase edges. A 12-bit counter wraps after 4096 reference cycles, so the bench can let it run up to 4095 and show a timestamp taken right at the top of the count and another taken just after the wrap. A short run also reaches the reset case, where a rise is still held between the sampling flops and the output register.

// File: rtl/mpt_pkg.sv
`timescale 1ns/1ps
package mpt_pkg;

    // Level of the hit line at the last sample of the previous reference cycle
    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_t;

    // Reference-clock edges between a cycle's first sample and its aligned vector
    localparam int unsigned ALIGN_LAG = 2;

endpackage

// File: rtl/mpt_phase_capture.sv
`timescale 1ns/1ps
// Samples the hit line on every phase clock and lands all samples of one
// reference cycle together in the clk_ph[0] domain, two edges later.
module mpt_phase_capture #(
    parameter int unsigned NUM_PHASES = 4
) (
    input  logic [NUM_PHASES-1:0] clk_ph,
    input  logic                  rst_n,
    input  logic                  hit,
    output logic [NUM_PHASES-1:0] aligned_vec
);

    localparam int unsigned HALF = NUM_PHASES / 2;

    logic [NUM_PHASES-1:0] raw_samp;
    logic [NUM_PHASES-1:0] landed;

    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
        logic samp_q;

        always_ff @(posedge clk_ph[i] or negedge rst_n) begin
            if (!rst_n) samp_q <= 1'b0;
            else        samp_q <= hit;
        end
        assign raw_samp[i] = samp_q;

        if (i > HALF) begin : g_hop
            // Late phases first cross half a period into an earlier phase,
            // so no path into the reference domain is shorter than half a period.
            logic hop_q;
            always_ff @(posedge clk_ph[i-HALF] or negedge rst_n) begin
                if (!rst_n) hop_q <= 1'b0;
                else        hop_q <= raw_samp[i];
            end
            assign landed[i] = hop_q;
        end else begin : g_direct
            logic pre_q;
            always_ff @(posedge clk_ph[0] or negedge rst_n) begin
                if (!rst_n) pre_q <= 1'b0;
                else        pre_q <= raw_samp[i];
            end
            assign landed[i] = pre_q;
        end
    end

    always_ff @(posedge clk_ph[0] or negedge rst_n) begin
        if (!rst_n) aligned_vec <= '0;
        else        aligned_vec <= landed;
    end

endmodule

// File: rtl/mpt_coarse_counter.sv
`timescale 1ns/1ps
// Single plain binary coarse counter in the reference domain.
module mpt_coarse_counter #(
    parameter int unsigned COARSE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] coarse_cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coarse_cnt <= '0;
        else        coarse_cnt <= coarse_cnt + 1'b1;
    end

endmodule

// File: rtl/mpt_edge_encoder.sv
`timescale 1ns/1ps
// Line-state machine plus first-rise encoder.
module mpt_edge_encoder
    import mpt_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4,
    parameter int unsigned COARSE_W   = 12,
    localparam int unsigned FINE_W    = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] aligned_vec,
    input  logic [COARSE_W-1:0]   coarse_cnt,
    output line_state_t           line_state,
    output logic                  ts_valid,
    output logic [COARSE_W-1:0]   ts_coarse,
    output logic [FINE_W-1:0]     ts_fine
);

    line_state_t           state_q, state_d;
    logic                  prev_bit;
    logic [NUM_PHASES-1:0] before_vec;
    logic [NUM_PHASES-1:0] rise_mask;
    logic [FINE_W-1:0]     first_idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    // Next state and encoding
    always_comb begin
        prev_bit = 1'b0;
        unique case (state_q)
            LINE_LOW:  prev_bit = 1'b0;
            LINE_HIGH: prev_bit = 1'b1;
        endcase
        state_d    = aligned_vec[NUM_PHASES-1] ? LINE_HIGH : LINE_LOW;
        before_vec = {aligned_vec[NUM_PHASES-2:0], prev_bit};
        rise_mask  = aligned_vec & ~before_vec;
        first_idx  = '0;
        for (int i = NUM_PHASES - 1; i >= 0; i--) begin
            if (rise_mask[i]) first_idx = FINE_W'(i);
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_valid  <= 1'b0;
            ts_coarse <= '0;
            ts_fine   <= '0;
        end else begin
            ts_valid <= |rise_mask;
            if (|rise_mask) begin
                ts_fine   <= first_idx;
                ts_coarse <= coarse_cnt - COARSE_W'(ALIGN_LAG);
            end
        end
    end

    assign line_state = state_q;

endmodule

// File: rtl/mpt_tdc_channel.sv
`timescale 1ns/1ps
// Four-phase sampling timestamp channel, top level.
module mpt_tdc_channel
    import mpt_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4,
    parameter int unsigned COARSE_W   = 12,
    localparam int unsigned FINE_W    = $clog2(NUM_PHASES)
) (
    input  logic [NUM_PHASES-1:0] clk_ph,
    input  logic                  rst_n,
    input  logic                  hit,
    output logic                  ts_valid,
    output logic [COARSE_W-1:0]   ts_coarse,
    output logic [FINE_W-1:0]     ts_fine
);

    logic [NUM_PHASES-1:0] aligned_vec;
    logic [COARSE_W-1:0]   coarse_cnt;
    line_state_t           line_state;

    mpt_phase_capture #(
        .NUM_PHASES (NUM_PHASES)
    ) u_capture (
        .clk_ph      (clk_ph),
        .rst_n       (rst_n),
        .hit         (hit),
        .aligned_vec (aligned_vec)
    );

    mpt_coarse_counter #(
        .COARSE_W (COARSE_W)
    ) u_counter (
        .clk        (clk_ph[0]),
        .rst_n      (rst_n),
        .coarse_cnt (coarse_cnt)
    );

    mpt_edge_encoder #(
        .NUM_PHASES (NUM_PHASES),
        .COARSE_W   (COARSE_W)
    ) u_encoder (
        .clk         (clk_ph[0]),
        .rst_n       (rst_n),
        .aligned_vec (aligned_vec),
        .coarse_cnt  (coarse_cnt),
        .line_state  (line_state),
        .ts_valid    (ts_valid),
        .ts_coarse   (ts_coarse),
        .ts_fine     (ts_fine)
    );

endmodule

// File: rtl/mpt_tdc_checker.sv
`timescale 1ns/1ps
module mpt_tdc_checker
    import mpt_pkg::*;
#(
    parameter int unsigned NUM_PHASES = 4,
    parameter int unsigned COARSE_W   = 12,
    localparam int unsigned FINE_W    = $clog2(NUM_PHASES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PHASES-1:0] aligned_vec,
    input line_state_t           line_state,
    input logic [COARSE_W-1:0]   coarse_cnt,
    input logic                  ts_valid,
    input logic [COARSE_W-1:0]   ts_coarse,
    input logic [FINE_W-1:0]     ts_fine
);

    logic [NUM_PHASES-1:0] vec_seen;
    always_ff @(posedge clk) vec_seen <= aligned_vec;

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> coarse_cnt == COARSE_W'($past(coarse_cnt) + 1'b1)); // R6

    AST_COARSE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (coarse_cnt == '1) |=> (coarse_cnt == '0)); // R7

    AST_TS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> ts_coarse == COARSE_W'(coarse_cnt - COARSE_W'(ALIGN_LAG + 1))); // R2

    AST_FINE_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid |-> vec_seen[ts_fine]); // R3

    AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_vec == '0) |=> !ts_valid); // R5

    AST_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_state == LINE_HIGH && (&aligned_vec)) |=> !ts_valid); // R5

endmodule

bind mpt_tdc_channel mpt_tdc_checker #(
    .NUM_PHASES (NUM_PHASES),
    .COARSE_W   (COARSE_W)
) u_chk (
    .clk         (clk_ph[0]),
    .rst_n       (rst_n),
    .aligned_vec (aligned_vec),
    .line_state  (line_state),
    .coarse_cnt  (coarse_cnt),
    .ts_valid    (ts_valid),
    .ts_coarse   (ts_coarse),
    .ts_fine     (ts_fine)
);

// File: tb/tb_mpt_tdc_channel.sv
`timescale 1ns/1ps
module tb_mpt_tdc_channel;

    logic c0, c90, c180, c270;
    logic rst_n;
    logic hit;
    logic        ts_valid;
    logic [11:0] ts_coarse;
    logic [1:0]  ts_fine;
    int n_checks;
    int n_fail;
    int bcnt;

    // 100 MHz phase clocks, each a quarter period after the previous one
    initial begin c0   = 0; #5.0;  forever #5 c0   = ~c0;   end
    initial begin c90  = 0; #7.5;  forever #5 c90  = ~c90;  end
    initial begin c180 = 0; #10.0; forever #5 c180 = ~c180; end
    initial begin c270 = 0; #12.5; forever #5 c270 = ~c270; end

    mpt_tdc_channel dut (
        .clk_ph    ({c270, c180, c90, c0}),
        .rst_n     (rst_n),
        .hit       (hit),
        .ts_valid  (ts_valid),
        .ts_coarse (ts_coarse),
        .ts_fine   (ts_fine)
    );

    // Bench model of the coarse time (R6, R7)
    always @(posedge c0 or negedge rst_n) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= (bcnt + 1) % 4096;
    end

    // lead pattern, test pattern, expect valid, expect fine; bit i = sample i
    localparam int NV = 14;
    localparam logic [10:0] VEC_TABLE [0:NV-1] = '{
        {4'b0000, 4'b0001, 1'b1, 2'd0},  // R1
        {4'b0000, 4'b0010, 1'b1, 2'd1},  // R1
        {4'b0000, 4'b1100, 1'b1, 2'd2},  // R1
        {4'b0000, 4'b1000, 1'b1, 2'd3},  // R1
        {4'b0000, 4'b1110, 1'b1, 2'd1},  // R3
        {4'b0000, 4'b0101, 1'b1, 2'd0},  // R4
        {4'b0000, 4'b1010, 1'b1, 2'd1},  // R4
        {4'b1000, 4'b0001, 1'b0, 2'd0},  // R3
        {4'b1000, 4'b0110, 1'b1, 2'd1},  // R3
        {4'b1000, 4'b1111, 1'b0, 2'd0},  // R5
        {4'b1111, 4'b0000, 1'b0, 2'd0},  // R5
        {4'b1000, 4'b1101, 1'b1, 2'd2},  // R4
        {4'b0000, 4'b0000, 1'b0, 2'd0},  // R5
        {4'b0111, 4'b1111, 1'b1, 2'd0}   // R3
    };

    function automatic string vec_tag(input int idx);
        case (idx)
            0, 1, 2, 3: return "R1";
            5, 6, 11:   return "R4";
            9, 10, 12:  return "R5";
            default:    return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drives one reference cycle; k returns the coarse value of that cycle
    task automatic drive_cycle(input logic [3:0] p, output int k);
        @(posedge c270); #1.25; hit = p[0];
        @(posedge c0);   #1.25; k = bcnt; hit = p[1];
        @(posedge c90);  #1.25; hit = p[2];
        @(posedge c180); #1.25; hit = p[3];
    endtask

    task automatic run_vec(input logic [3:0] lead, input logic [3:0] test,
                           input logic ev, input int ef, input string tag,
                           output int k);
        int unused_k;
        drive_cycle(lead, unused_k);
        drive_cycle(test, k);
        repeat (3) @(posedge c0);
        #1.25;
        check({tag, " valid"}, ts_valid, ev);
        if (ev) begin
            check({tag, " fine"}, ts_fine, ef);
            check({tag, " coarse"}, ts_coarse, k);
        end
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int k;
        n_checks = 0;
        n_fail   = 0;
        hit      = 1'b0;
        rst_n    = 1'b0;
        repeat (3) @(posedge c0);
        #1.25;
        check("R8 reset valid", ts_valid, 0);
        check("R8 reset coarse", ts_coarse, 0);
        check("R8 reset fine", ts_fine, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge c0);

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC_TABLE[v][10:7], VEC_TABLE[v][6:3], VEC_TABLE[v][2],
                    int'(VEC_TABLE[v][1:0]), vec_tag(v), k);
        end

        // R2: strobe lands after the third reference edge, for one cycle
        drive_cycle(4'b0000, k);
        drive_cycle(4'b0100, k);
        repeat (2) @(posedge c0); #1.25;
        check("R2 early", ts_valid, 0);
        @(posedge c0); #1.25;
        check("R2 on time", ts_valid, 1);
        check("R2 fine", ts_fine, 2);
        check("R2 coarse", ts_coarse, k);
        @(posedge c0); #1.25;
        check("R2 single pulse", ts_valid, 0);

        // R8: pending rise dropped by reset
        drive_cycle(4'b0000, k);
        drive_cycle(4'b0011, k);
        @(posedge c0); #1.25;
        rst_n = 1'b0;
        #1;
        check("R8 valid in reset", ts_valid, 0);
        @(posedge c0); #1.25;
        rst_n = 1'b1;
        for (int j = 0; j < 4; j++) begin
            @(posedge c0); #1.25;
            check("R8 no stale timestamp", ts_valid, 0);
        end

        // R7: timestamps at the top of the count and after the wrap
        do begin
            @(posedge c0); #1.25;
        end while (bcnt != 4093);
        run_vec(4'b0000, 4'b0100, 1'b1, 2, "R7", k);
        check("R7 top cycle", k, 4095);
        check("R7 top coarse", ts_coarse, 4095);
        run_vec(4'b0000, 4'b0010, 1'b1, 1, "R7", k);
        check("R7 wrapped cycle", k, 4);
        check("R7 wrapped coarse", ts_coarse, 4);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule